// File: doc/BRIEF.md
# PS/2 Host Serial Channel

This block is the host end of a two-wire PS/2 link. The attached device always generates the clock. The block only ever pulls the clock and data lines low through open-drain output enables, and it releases them otherwise. Both directions carry 11-bit frames: a start bit of 0, eight data bits with the least significant bit first, an odd parity bit, and a stop bit of 1. Line sampling is timed by a 2 MHz tick input. The tick may be held high continuously to run faster, and each cycle with the tick high counts as one 0.5 µs tick.

In receive mode the block collects frames on falling edges of the device clock. A good byte is offered on a valid/ready output. Back-pressure is the point of the interface: while `rx_valid` is high and `rx_ready` is low, the byte is frozen and the clock line is held low, so the device cannot start another frame. In transmit mode a byte is accepted when `tx_valid` and `tx_ready` are both high. The block then holds the clock low for the inhibit time, pulls data low, releases the clock, and shifts the frame out on the device's clock. Finally it samples the device acknowledge.

A status word collects events, and any set bit raises the activity interrupt. A separate wake output latches a falling edge of the raw data line with no clock involved. A sleep-permission output tells the system when the channel may be put to sleep.

Top module: `ps2_host_chan`

## Requirements
- R1: In receive mode, a frame whose bit cells are anywhere from 120 to 200 ticks long is assembled least significant bit first and presented on `rx_data` with `rx_valid` high. `status[0]` mirrors `rx_valid`.
- R2: While `rx_valid` is high and `rx_ready` is low, `rx_data` stays stable and `ps2_clk_oe` is high. A cycle with `rx_valid` and `rx_ready` both high consumes the byte and releases the clock.
- R3: A received frame whose parity is not odd over data plus parity sets `status[3]`, and its byte is not delivered.
- R4: A start bit of 1 sets `status[2]`, and a stop bit of 0 sets `status[4]`. Neither kind of frame is delivered.
- R5: If no device clock falling edge arrives for TIMEOUT_TICKS ticks during a frame, in either direction, the block sets `status[5]` and returns to idle.
- R6: In transmit mode, an accepted byte first holds the clock low for at least INHIBIT_TICKS ticks. The block then drives data low and releases the clock. On device clock falling edges 1 to 10 it puts out data bits 0 to 7, then odd parity, then a released stop bit. When idle (`tx_ready` high) it never drives data.
- R7: On the 11th device clock falling edge, data low sets `status[1]` (done) and data high sets `status[6]` (no acknowledge).
- R8: The clock line is pulled low only during the transmit inhibit window or while a received byte is held.
- R9: `sleep_ok` is high when `enable` is low. It is also high in receive mode when no frame is in progress and the clock line is high or held by the block. It is low otherwise.
- R10: With `wake_en` high, a falling edge on `ps2_dat_in` raises `wake_req` at once, with no clock edge needed. `wake_clr` clears it. With `wake_en` low, data edges leave `wake_req` low.
- R11: Status bits 6..1 are sticky. Writing 1 to the matching `stat_clr` bit clears only that bit. `act_irq` is high whenever any status bit is set.
- R12: With `enable` low, both output enables are released, `tx_ready` is low, and bus traffic is ignored. No byte is delivered and no status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 2 MHz timing tick, one cycle wide or continuous |
| enable | input | 1 | Channel enable |
| mode_tx | input | 1 | 1 selects transmit mode, 0 selects receive mode |
| ps2_clk_in | input | 1 | Clock line level |
| ps2_dat_in | input | 1 | Data line level |
| ps2_clk_oe | output | 1 | Pull clock line low |
| ps2_dat_oe | output | 1 | Pull data line low |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter idle and able to accept a byte |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte held |
| rx_ready | input | 1 | Consumer takes the held byte |
| rx_data | output | 8 | Received byte |
| stat_clr | input | 6 | Write-one-to-clear for status bits 6..1 |
| status | output | 7 | {nack, timeout, stop err, parity err, start err, tx done, rx full} |
| act_irq | output | 1 | Activity interrupt, OR of all status bits |
| wake_en | input | 1 | Arm the data-line wake latch |
| wake_clr | input | 1 | Clear the wake latch |
| wake_req | output | 1 | Wake request |
| sleep_ok | output | 1 | Channel may be put to sleep |

## Verification
With the tick held high, a device clock fall reaches the state machines about four to six cycles after it happens on the line: two synchronizer stages, a two-tick deglitch window, and the edge register. A frame result or status bit therefore appears a few cycles after the last fall. The bench samples each frame result at least twenty cycles after the device model's final clock edge, on a falling system-clock edge. Timeouts are checked on both sides of TIMEOUT_TICKS, about 100 ticks before and 150 ticks after. The inhibit window is counted cycle by cycle from the line itself. The wake latch is checked one nanosecond after the data fall, before any clock edge can intervene.

// File: rtl/ps2_chan_pkg.sv
package ps2_chan_pkg;
  localparam int ST_W = 7;
  localparam int ST_RXF  = 0;
  localparam int ST_TXD  = 1;
  localparam int ST_SERR = 2;
  localparam int ST_PERR = 3;
  localparam int ST_XERR = 4;
  localparam int ST_TMO  = 5;
  localparam int ST_NACK = 6;

  typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_HOLD} rx_st_e;
  typedef enum logic [1:0] {TX_IDLE, TX_INH, TX_SHIFT} tx_st_e;

  typedef struct packed {
    logic start_err;
    logic par_err;
    logic stop_err;
    logic tmo;
  } rx_evt_t;

  function automatic logic odd_par(input logic [7:0] d);
    return ~^d;
  endfunction
endpackage

// File: rtl/ps2_line_filt.sv
module ps2_line_filt #(
  parameter int FILT_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic level
);
  localparam int CW = (FILT_TICKS < 2) ? 1 : $clog2(FILT_TICKS + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      level  <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (sync_q[1] == level) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q == CW'(FILT_TICKS - 1)) begin
          level <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ps2_rx.sv
module ps2_rx
  import ps2_chan_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       active,
  input  logic       clk_fall,
  input  logic       dat_lvl,
  input  logic       rx_ready,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       hold,
  output logic       busy,
  output rx_evt_t    evt
);
  localparam int TW = $clog2(TIMEOUT_TICKS + 1);

  rx_st_e        st_q;
  logic [9:0]    sh_q;
  logic [3:0]    bcnt_q;
  logic [TW-1:0] tcnt_q;
  logic [9:0]    word;

  assign word = {dat_lvl, sh_q[9:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      sh_q    <= '0;
      bcnt_q  <= '0;
      tcnt_q  <= '0;
      rx_data <= '0;
      evt     <= '0;
    end else begin
      evt <= '0;
      if (!active) begin
        st_q   <= RX_IDLE;
        bcnt_q <= '0;
        tcnt_q <= '0;
      end else begin
        unique case (st_q)
          RX_IDLE: begin
            if (clk_fall) begin
              if (dat_lvl) begin
                evt.start_err <= 1'b1;
              end else begin
                st_q   <= RX_BITS;
                bcnt_q <= '0;
                tcnt_q <= '0;
              end
            end
          end
          RX_BITS: begin
            if (clk_fall) begin
              tcnt_q <= '0;
              sh_q   <= word;
              bcnt_q <= bcnt_q + 1'b1;
              if (bcnt_q == 4'd9) begin
                if (~^word[8:0] || !dat_lvl) begin
                  evt.par_err  <= ~^word[8:0];
                  evt.stop_err <= ~dat_lvl;
                  st_q         <= RX_IDLE;
                end else begin
                  rx_data <= word[7:0];
                  st_q    <= RX_HOLD;
                end
              end
            end else if (tick) begin
              if (tcnt_q == TW'(TIMEOUT_TICKS - 1)) begin
                evt.tmo <= 1'b1;
                st_q    <= RX_IDLE;
              end else begin
                tcnt_q <= tcnt_q + 1'b1;
              end
            end
          end
          RX_HOLD: begin
            if (rx_ready) st_q <= RX_IDLE;
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign rx_valid = (st_q == RX_HOLD);
  assign hold     = (st_q == RX_HOLD);
  assign busy     = (st_q == RX_BITS);
endmodule

// File: rtl/ps2_tx.sv
module ps2_tx
  import ps2_chan_pkg::*;
#(
  parameter int INHIBIT_TICKS = 200,
  parameter int TIMEOUT_TICKS = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       active,
  input  logic       clk_fall,
  input  logic       dat_lvl,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  output logic       clk_oe,
  output logic       dat_oe,
  output logic       inhibit,
  output logic       done,
  output logic       nack,
  output logic       tmo
);
  localparam int TMAX = (INHIBIT_TICKS > TIMEOUT_TICKS) ? INHIBIT_TICKS : TIMEOUT_TICKS;
  localparam int TW   = $clog2(TMAX + 1);

  tx_st_e        st_q;
  logic [9:0]    frame_q;
  logic [3:0]    cnt_q;
  logic [TW-1:0] tcnt_q;

  assign tx_ready = active && (st_q == TX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TX_IDLE;
      frame_q <= '0;
      cnt_q   <= '0;
      tcnt_q  <= '0;
      dat_oe  <= 1'b0;
      done    <= 1'b0;
      nack    <= 1'b0;
      tmo     <= 1'b0;
    end else begin
      done <= 1'b0;
      nack <= 1'b0;
      tmo  <= 1'b0;
      if (!active) begin
        st_q   <= TX_IDLE;
        dat_oe <= 1'b0;
      end else begin
        unique case (st_q)
          TX_IDLE: begin
            if (tx_valid) begin
              frame_q <= {1'b1, odd_par(tx_data), tx_data};
              tcnt_q  <= '0;
              cnt_q   <= '0;
              st_q    <= TX_INH;
            end
          end
          TX_INH: begin
            if (tick) begin
              if (tcnt_q == TW'(INHIBIT_TICKS - 1)) begin
                tcnt_q <= '0;
                dat_oe <= 1'b1;
                st_q   <= TX_SHIFT;
              end else begin
                tcnt_q <= tcnt_q + 1'b1;
              end
            end
          end
          TX_SHIFT: begin
            if (clk_fall) begin
              tcnt_q <= '0;
              if (cnt_q == 4'd10) begin
                dat_oe <= 1'b0;
                nack   <= dat_lvl;
                done   <= ~dat_lvl;
                st_q   <= TX_IDLE;
              end else begin
                dat_oe  <= ~frame_q[0];
                frame_q <= {1'b0, frame_q[9:1]};
                cnt_q   <= cnt_q + 1'b1;
              end
            end else if (tick) begin
              if (tcnt_q == TW'(TIMEOUT_TICKS - 1)) begin
                tmo    <= 1'b1;
                dat_oe <= 1'b0;
                st_q   <= TX_IDLE;
              end else begin
                tcnt_q <= tcnt_q + 1'b1;
              end
            end
          end
          default: st_q <= TX_IDLE;
        endcase
      end
    end
  end

  assign inhibit = (st_q == TX_INH);
  assign clk_oe  = inhibit;
endmodule

// File: rtl/ps2_host_chan.sv
module ps2_host_chan
  import ps2_chan_pkg::*;
#(
  parameter int FILT_TICKS    = 2,
  parameter int INHIBIT_TICKS = 200,
  parameter int TIMEOUT_TICKS = 4000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            enable,
  input  logic            mode_tx,
  input  logic            ps2_clk_in,
  input  logic            ps2_dat_in,
  output logic            ps2_clk_oe,
  output logic            ps2_dat_oe,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic [7:0]      tx_data,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic [7:0]      rx_data,
  input  logic [ST_W-1:1] stat_clr,
  output logic [ST_W-1:0] status,
  output logic            act_irq,
  input  logic            wake_en,
  input  logic            wake_clr,
  output logic            wake_req,
  output logic            sleep_ok
);
  logic [1:0] raw_lines, lvl;
  logic       clk_q, clk_fall;
  logic       rx_act, tx_act, rx_hold, rx_busy;
  logic       tx_clk_oe, tx_inh, tx_done, tx_nack, tx_tmo;
  rx_evt_t    rx_evt;
  logic [ST_W-1:1] sticky_q, set_vec;
  logic       wake_clr_q, wake_arst, wake_flag;

  assign raw_lines = {ps2_dat_in, ps2_clk_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    ps2_line_filt #(.FILT_TICKS(FILT_TICKS)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .raw   (raw_lines[g]),
      .level (lvl[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_q <= 1'b1;
    else        clk_q <= lvl[0];
  end
  assign clk_fall = clk_q & ~lvl[0];

  assign rx_act = enable & ~mode_tx;
  assign tx_act = enable &  mode_tx;

  ps2_rx #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .active   (rx_act),
    .clk_fall (clk_fall),
    .dat_lvl  (lvl[1]),
    .rx_ready (rx_ready),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .hold     (rx_hold),
    .busy     (rx_busy),
    .evt      (rx_evt)
  );

  ps2_tx #(.INHIBIT_TICKS(INHIBIT_TICKS), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .active   (tx_act),
    .clk_fall (clk_fall),
    .dat_lvl  (lvl[1]),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .clk_oe   (tx_clk_oe),
    .dat_oe   (ps2_dat_oe),
    .inhibit  (tx_inh),
    .done     (tx_done),
    .nack     (tx_nack),
    .tmo      (tx_tmo)
  );

  assign ps2_clk_oe = rx_hold | tx_clk_oe;

  always_comb begin
    set_vec          = '0;
    set_vec[ST_TXD]  = tx_done;
    set_vec[ST_SERR] = rx_evt.start_err;
    set_vec[ST_PERR] = rx_evt.par_err;
    set_vec[ST_XERR] = rx_evt.stop_err;
    set_vec[ST_TMO]  = rx_evt.tmo | tx_tmo;
    set_vec[ST_NACK] = tx_nack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= (sticky_q & ~stat_clr) | set_vec;
  end

  assign status  = {sticky_q, rx_valid};
  assign act_irq = |status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_clr_q <= 1'b0;
    else        wake_clr_q <= wake_clr;
  end
  assign wake_arst = ~rst_n | wake_clr_q;

  always_ff @(negedge ps2_dat_in or posedge wake_arst) begin
    if (wake_arst)    wake_flag <= 1'b0;
    else if (wake_en) wake_flag <= 1'b1;
  end
  assign wake_req = wake_flag;

  assign sleep_ok = ~enable | (~mode_tx & ~rx_busy & (lvl[0] | rx_hold));
endmodule

// File: rtl/ps2_host_chan_chk.sv
module ps2_host_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       ps2_clk_oe,
  input logic       ps2_dat_oe,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic [6:1] stat_clr,
  input logic [6:0] status,
  input logic       sleep_ok,
  input logic       tx_inh
);
  // R2
  rx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  // R2
  rx_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ps2_clk_oe);

  // R8
  clk_drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ps2_clk_oe |-> (rx_valid || tx_inh));

  // R6
  tx_idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !ps2_dat_oe);

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] && !stat_clr[1] |=> status[1]);

  // R12
  disabled_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (enable || (!ps2_clk_oe && !ps2_dat_oe && !tx_ready && !rx_valid)));

  // R9
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ok && enable |-> !ps2_dat_oe && !tx_inh);
endmodule

bind ps2_host_chan ps2_host_chan_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .ps2_clk_oe (ps2_clk_oe),
  .ps2_dat_oe (ps2_dat_oe),
  .tx_ready   (tx_ready),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_data    (rx_data),
  .stat_clr   (stat_clr),
  .status     (status),
  .sleep_ok   (sleep_ok),
  .tx_inh     (tx_inh)
);

// File: tb/ps2_host_chan_tb.sv
module ps2_host_chan_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic enable = 1'b0, mode_tx = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic [7:0] tx_data = '0;
  logic [6:1] stat_clr = '0;
  logic wake_en = 1'b0, wake_clr = 1'b0;
  logic dev_clk = 1'b1, dev_dat = 1'b1;
  logic ps2_clk_oe, ps2_dat_oe, tx_ready, rx_valid, act_irq, wake_req, sleep_ok;
  logic [7:0] rx_data;
  logic [6:0] status;
  logic clk_line, dat_line;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  assign clk_line = dev_clk & ~ps2_clk_oe;
  assign dat_line = dev_dat & ~ps2_dat_oe;

  ps2_host_chan u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable), .mode_tx(mode_tx),
    .ps2_clk_in(clk_line), .ps2_dat_in(dat_line),
    .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .stat_clr(stat_clr), .status(status), .act_irq(act_irq),
    .wake_en(wake_en), .wake_clr(wake_clr), .wake_req(wake_req), .sleep_ok(sleep_ok)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // device-to-host frame; nbits < 11 stops early
  task automatic dev_send(input logic [7:0] d, input int h, input bit bad_start,
                          input bit bad_par, input bit bad_stop, input int nbits);
    logic [10:0] f;
    f = {~bad_stop, (~^d) ^ bad_par, d, bad_start};
    wait (clk_line == 1'b1);
    for (int i = 0; i < nbits; i++) begin
      dev_dat = f[i];
      #(h * 10);
      dev_clk = 1'b0;
      #(h * 10);
      dev_clk = 1'b1;
    end
    dev_dat = 1'b1;
  endtask

  // host-to-device frame as seen by the device
  task automatic dev_recv(input bit ack, input int h, output logic [9:0] bits,
                          output int inh, output logic start_low);
    inh = 0;
    wait (clk_line == 1'b0);
    while (clk_line == 1'b0) begin
      @(negedge clk);
      if (clk_line == 1'b0) inh++;
    end
    start_low = ~dat_line;
    for (int i = 0; i < 11; i++) begin
      if (i == 10) dev_dat = ~ack;
      #(h * 10);
      dev_clk = 1'b0;
      #(h * 10);
      if (i < 10) bits[i] = dat_line;
      dev_clk = 1'b1;
    end
    dev_dat = 1'b1;
  endtask

  task automatic consume;
    @(negedge clk) rx_ready = 1'b1;
    @(negedge clk) rx_ready = 1'b0;
    cyc(2);
  endtask

  task automatic clear_all;
    @(negedge clk) stat_clr = '1;
    @(negedge clk) stat_clr = '0;
  endtask

  task automatic t_reset;
    cyc(2);
    chk("R12", "status after reset", status, 7'h00);
    chk("R12", "oe after reset", {ps2_clk_oe, ps2_dat_oe}, 2'b00);
    chk("R12", "tx_ready disabled", tx_ready, 1'b0);
    chk("R9", "sleep_ok disabled", sleep_ok, 1'b1);
    chk("R10", "wake_req after reset", wake_req, 1'b0);
  endtask

  task automatic t_rx_basic;
    enable = 1'b1; mode_tx = 1'b0;
    cyc(4);
    chk("R9", "sleep_ok rx idle", sleep_ok, 1'b1);
    dev_send(8'hA5, 60, 0, 0, 0, 11);
    cyc(20);
    chk("R1", "rx_valid", rx_valid, 1'b1);
    chk("R1", "rx_data", rx_data, 8'hA5);
    chk("R1", "status rx full", status[0], 1'b1);
    chk("R11", "act_irq on rx", act_irq, 1'b1);
    chk("R2", "clock held", ps2_clk_oe, 1'b1);
    cyc(100);
    chk("R2", "still held data", {ps2_clk_oe, rx_valid, rx_data}, {2'b11, 8'hA5});
    chk("R9", "sleep_ok while held", sleep_ok, 1'b1);
    consume();
    chk("R2", "released after take", {rx_valid, ps2_clk_oe}, 2'b00);
  endtask

  task automatic t_rx_slow;
    dev_send(8'h80, 100, 0, 0, 0, 11);
    cyc(20);
    chk("R1", "slow cell data", {rx_valid, rx_data}, {1'b1, 8'h80});
    consume();
    dev_send(8'h01, 60, 0, 0, 0, 11);
    cyc(20);
    chk("R1", "lsb first data", {rx_valid, rx_data}, {1'b1, 8'h01});
    consume();
  endtask

  task automatic t_rx_parity;
    dev_send(8'h5A, 60, 0, 1, 0, 11);
    cyc(20);
    chk("R3", "parity flag", status[3], 1'b1);
    chk("R3", "no delivery", rx_valid, 1'b0);
    chk("R11", "irq on error", act_irq, 1'b1);
    @(negedge clk) stat_clr = 6'b000010;
    @(negedge clk) stat_clr = '0;
    chk("R11", "other bit kept", status[3], 1'b1);
    @(negedge clk) stat_clr = 6'b000100;
    @(negedge clk) stat_clr = '0;
    chk("R11", "w1c cleared", {status, act_irq}, 8'h00);
  endtask

  task automatic t_rx_framing;
    dev_send(8'h11, 60, 0, 0, 1, 11);
    cyc(20);
    chk("R4", "stop flag", {status[4], rx_valid}, 2'b10);
    clear_all();
    dev_send(8'hFF, 60, 1, 0, 0, 11);
    cyc(20);
    chk("R4", "start flag only", status, 7'b0000100);
    clear_all();
  endtask

  task automatic t_rx_timeout;
    dev_send(8'hC3, 60, 0, 0, 0, 4);
    cyc(3900 - 60);
    chk("R5", "no early timeout", status[5], 1'b0);
    chk("R9", "no sleep mid frame", sleep_ok, 1'b0);
    cyc(250);
    chk("R5", "rx timeout", status[5], 1'b1);
    chk("R9", "sleep after abort", sleep_ok, 1'b1);
    clear_all();
  endtask

  task automatic t_tx(input logic [7:0] d, input bit ack);
    logic [9:0] bits;
    int inh;
    logic st_low;
    mode_tx = 1'b1;
    cyc(4);
    chk("R6", "tx_ready idle", tx_ready, 1'b1);
    chk("R9", "no sleep in tx", sleep_ok, 1'b0);
    fork
      dev_recv(ack, 60, bits, inh, st_low);
      begin
        @(negedge clk) begin tx_valid = 1'b1; tx_data = d; end
        @(negedge clk) tx_valid = 1'b0;
      end
    join
    cyc(20);
    chk("R6", "inhibit long enough", (inh >= 200), 1'b1);
    chk("R6", "start low", st_low, 1'b1);
    chk("R6", "frame bits", bits, {1'b1, ~^d, d});
    chk("R7", "done/nack", {status[6], status[1]}, ack ? 2'b01 : 2'b10);
    chk("R6", "idle again", {tx_ready, ps2_dat_oe, ps2_clk_oe}, 3'b100);
    clear_all();
  endtask

  task automatic t_tx_timeout;
    @(negedge clk) begin tx_valid = 1'b1; tx_data = 8'h42; end
    @(negedge clk) tx_valid = 1'b0;
    wait (clk_line == 1'b0);
    wait (clk_line == 1'b1);
    cyc(4150);
    chk("R5", "tx timeout", {status[5], tx_ready, ps2_dat_oe}, 3'b110);
    clear_all();
  endtask

  task automatic t_disabled;
    enable = 1'b0; mode_tx = 1'b0;
    cyc(4);
    dev_send(8'h77, 60, 0, 0, 0, 11);
    cyc(20);
    chk("R12", "no rx when off", {rx_valid, status}, 8'h00);
    chk("R12", "lines released", {ps2_clk_oe, ps2_dat_oe}, 2'b00);
    @(negedge clk) tx_valid = 1'b1;
    chk("R12", "tx_ready off", tx_ready, 1'b0);
    @(negedge clk) tx_valid = 1'b0;
  endtask

  task automatic t_wake;
    @(posedge clk); #2 dev_dat = 1'b0;
    #1 chk("R10", "unarmed stays low", wake_req, 1'b0);
    @(negedge clk) dev_dat = 1'b1;
    wake_en = 1'b1;
    @(posedge clk); #2 dev_dat = 1'b0;
    #1 chk("R10", "clockless wake", wake_req, 1'b1);
    @(negedge clk) begin dev_dat = 1'b1; wake_en = 1'b0; wake_clr = 1'b1; end
    @(negedge clk) wake_clr = 1'b0;
    cyc(1);
    chk("R10", "wake cleared", wake_req, 1'b0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_rx_basic();
    t_rx_slow();
    t_rx_parity();
    t_rx_framing();
    t_rx_timeout();
    t_tx(8'h5B, 1'b1);
    t_tx(8'hE0, 1'b0);
    t_tx_timeout();
    t_disabled();
    t_wake();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule